// File: doc/BRIEF.md
# Index-Calculus Residue Multiplier

This block multiplies two residues modulo a fixed modulus without a hardware multiplier. Each nonzero operand is turned into a short index code by a lookup table. The indices are added under the rules that belong to the kind of modulus. An inverse lookup then turns the summed code back into a residue. One instance serves one modulus. A parameter picks one of three kinds of modulus: a prime p, an odd prime power p^k, or a power of two 2^m. All lookup tables are computed while the design is elaborated, from the modulus, the generator and the exponent.

For a prime, an operand is g^i mod p, and indices add modulo p-1. For an odd prime power, an operand is g^a * p^b. The a fields add modulo (p-1)p^(k-1), and the b fields add as plain integers. For a power of two, an operand is 2^a * 5^b * (-1)^c. The a fields add as plain integers, the b fields add modulo 2^(m-2), and the c fields combine by exclusive OR. Zero has no index, so a separate flag carries it past the index arithmetic and forces a zero product.

The block is used inside the parallel residue channels of a filter datapath. Operands enter with a valid strobe, and the product leaves with a matching strobe two clock cycles later.

Top module: `modmul_index`

## Requirements
- R1: `out_vld_o` is high exactly two rising clock edges after each cycle in which `in_vld_i` is high, and is low in every other cycle.
- R2: For a prime modulus with generator g (roots 2, 3, 2, 3, 5, 2 for p = 29, 31, 37, 43, 47, 59), nonzero operands give `prod_o` = (a*b) mod p.
- R3: If either operand is 0, `prod_o` is 0, for every kind of modulus.
- R4: For an odd prime power (25 = 5^2, generator 2), a pair with at least one operand not divisible by 5 gives `prod_o` = (a*b) mod 25.
- R5: For an odd prime power, when the sum of the power-of-p fields of the two operands reaches k or more, `prod_o` is 0. For 25, this means both operands are multiples of 5.
- R6: For a power of two 2^m (64, m = 6), nonzero operands whose counts of trailing zero bits sum to less than m-1 give `prod_o` = (a*b) mod 2^m.
- R7: For a power of two, when the trailing-zero counts sum to exactly m-1, `prod_o` is 2^(m-1), which is 32 for 64.
- R8: For a power of two, when the trailing-zero counts sum to more than m-1, `prod_o` is 0.
- R9: While `rst_n` is low at a rising edge, the next state has `out_vld_o` = 0 and `prod_o` = 0.
- R10: Operands presented with `in_vld_i` are below the modulus, and every valid `prod_o` is below the modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld_i | input | 1 | Operand pair is valid this cycle |
| opa_i | input | $clog2(MODULUS) | First residue operand |
| opb_i | input | $clog2(MODULUS) | Second residue operand |
| out_vld_o | output | 1 | Product is valid this cycle |
| prod_o | output | $clog2(MODULUS) | Residue product, held between valid cycles |

## Verification
The hardest cases to reach are the boundary cases of the non-prime moduli. For 64, these are pairs whose trailing-zero counts sum to exactly five, where the odd part of the product must be dropped. For 25, these are pairs where both operands are multiples of 5. There are few such pairs, and any encoding slip shows up only there. The bench therefore runs every operand pair, zero included, for all eight moduli at once, one instance per modulus. It tags each pair with the requirement that governs it. It also inserts idle cycles at irregular points, so that the two-cycle valid alignment is checked across gaps as well as in back-to-back streams.

// File: rtl/modmul_pkg.sv
// Shared types and elaboration-time helpers for the index-calculus multiplier.
// Assumes all arguments are small enough that products fit in a 32-bit int.
package modmul_pkg;

    typedef enum logic [1:0] {
        MOD_PRIME   = 2'd0,
        MOD_ODD_POW = 2'd1,
        MOD_POW2    = 2'd2
    } mod_kind_e;

    // g^e mod m by repeated multiplication (elaboration only)
    function automatic int powmod(input int g, input int e, input int m);
        int r;
        r = 1 % m;
        for (int i = 0; i < e; i++) begin
            r = (r * g) % m;
        end
        return r;
    endfunction

    // Residue represented by the index fields (alpha, beta, gamma)
    function automatic int code_value(input mod_kind_e kind, input int m,
                                      input int root, input int base,
                                      input int alpha, input int beta,
                                      input int gamma);
        int v;
        case (kind)
            MOD_PRIME:   v = powmod(root, alpha, m);
            MOD_ODD_POW: v = (powmod(root, alpha, m) * powmod(base, beta, m)) % m;
            default: begin
                v = (powmod(2, alpha, m) * powmod(5, beta, m)) % m;
                if (gamma != 0) v = (m - v) % m;
            end
        endcase
        return v;
    endfunction

    // Packed code {gamma, beta, alpha} of a residue, or -1 if none exists
    function automatic int code_search(input mod_kind_e kind, input int m,
                                       input int root, input int base,
                                       input int aw, input int bw,
                                       input int alim, input int blim,
                                       input int glim, input int target);
        int code;
        bit found;
        code  = -1;
        found = 1'b0;
        for (int c = 0; c < glim; c++) begin
            for (int b = 0; b < blim; b++) begin
                for (int a = 0; a < alim; a++) begin
                    if (!found && code_value(kind, m, root, base, a, b, c) == target) begin
                        code  = a | (b << aw) | (c << (aw + bw));
                        found = 1'b1;
                    end
                end
            end
        end
        return code;
    endfunction

endpackage

// File: rtl/modmul_fwd_rom.sv
// Forward index table: maps a residue to its packed index code.
// Assumes val_i < MODULUS; entries at and above MODULUS hold code 0.
// Zero has no index and is reported separately on zero_o.
module modmul_fwd_rom
    import modmul_pkg::*;
#(
    parameter mod_kind_e KIND      = MOD_ODD_POW,
    parameter int        MODULUS   = 25,
    parameter int        ROOT      = 2,
    parameter int        BASE      = 5,
    parameter int        AW        = 5,
    parameter int        BW        = 1,
    parameter int        ALPHA_LIM = 20,
    parameter int        BETA_LIM  = 2,
    parameter int        GAMMA_LIM = 1,
    localparam int       VW        = $clog2(MODULUS),
    localparam int       CW        = AW + BW + 1
) (
    input  logic [VW-1:0] val_i,
    output logic [CW-1:0] code_o,
    output logic          zero_o
);

    localparam int DEPTH = 1 << VW;

    logic [CW-1:0] fwd_rom [DEPTH];

    // One constant entry per residue, computed at elaboration
    for (genvar v = 0; v < DEPTH; v++) begin : g_entry
        localparam int C_RAW = (v > 0 && v < MODULUS)
            ? code_search(KIND, MODULUS, ROOT, BASE, AW, BW,
                          ALPHA_LIM, BETA_LIM, GAMMA_LIM, v)
            : 0;
        localparam int C_VAL = (C_RAW < 0) ? 0 : C_RAW;
        assign fwd_rom[v] = CW'(C_VAL);
    end

    // Table read and zero detection
    always_comb begin
        code_o = fwd_rom[val_i];
        zero_o = (val_i == '0);
    end

endmodule

// File: rtl/modmul_idx_add.sv
// Index adder: combines two packed index codes under the rules of the
// selected modulus kind and flags a zero product (zero operand or overflow).
// Assumes input codes come from modmul_fwd_rom with the same parameters.
module modmul_idx_add
    import modmul_pkg::*;
#(
    parameter mod_kind_e KIND      = MOD_ODD_POW,
    parameter int        EXPONENT  = 2,
    parameter int        AW        = 5,
    parameter int        BW        = 1,
    parameter int        ALPHA_LIM = 20,
    localparam int       CW        = AW + BW + 1
) (
    input  logic [CW-1:0] code_a_i,
    input  logic [CW-1:0] code_b_i,
    input  logic          zero_a_i,
    input  logic          zero_b_i,
    output logic [CW-1:0] code_o,
    output logic          zero_o
);

    logic [AW-1:0] alpha_a, alpha_b, alpha_res;
    logic [BW-1:0] beta_a, beta_b, beta_res;
    logic          gamma_a, gamma_b, gamma_res;
    logic [AW:0]   alpha_sum;
    logic [BW:0]   beta_sum;
    logic          ovf;

    // Field split of both codes and raw field sums
    always_comb begin
        alpha_a   = code_a_i[AW-1:0];
        alpha_b   = code_b_i[AW-1:0];
        beta_a    = code_a_i[AW+BW-1:AW];
        beta_b    = code_b_i[AW+BW-1:AW];
        gamma_a   = code_a_i[CW-1];
        gamma_b   = code_b_i[CW-1];
        alpha_sum = {1'b0, alpha_a} + {1'b0, alpha_b};
        beta_sum  = {1'b0, beta_a} + {1'b0, beta_b};
    end

    if (KIND == MOD_POW2) begin : g_pow2
        logic alpha_edge;
        // Linear alpha, beta wraps at 2^BW, gamma by XOR; edge drops odd part
        always_comb begin
            alpha_edge = (alpha_sum == (AW+1)'(EXPONENT - 1));
            ovf        = (alpha_sum >  (AW+1)'(EXPONENT - 1));
            alpha_res  = alpha_sum[AW-1:0];
            beta_res   = alpha_edge ? '0 : beta_sum[BW-1:0];
            gamma_res  = alpha_edge ? 1'b0 : (gamma_a ^ gamma_b);
        end
    end else begin : g_cyclic
        // Alpha modulo the group order; beta linear for prime powers only
        always_comb begin
            alpha_res = (alpha_sum >= (AW+1)'(ALPHA_LIM))
                      ? AW'(alpha_sum - (AW+1)'(ALPHA_LIM))
                      : alpha_sum[AW-1:0];
            gamma_res = 1'b0;
            if (KIND == MOD_ODD_POW) begin
                ovf      = (beta_sum > (BW+1)'(EXPONENT - 1));
                beta_res = beta_sum[BW-1:0];
            end else begin
                ovf      = 1'b0;
                beta_res = '0;
            end
        end
    end

    logic unused_fields;
    assign unused_fields = ^{gamma_a, gamma_b, beta_sum[BW]};

    // Output code and zero decision
    always_comb begin
        code_o = {gamma_res, beta_res, alpha_res};
        zero_o = zero_a_i | zero_b_i | ovf;
    end

endmodule

// File: rtl/modmul_inv_rom.sv
// Inverse index table: maps a packed index code back to a residue.
// A set zero_i overrides the table and yields residue 0.
module modmul_inv_rom
    import modmul_pkg::*;
#(
    parameter mod_kind_e KIND    = MOD_ODD_POW,
    parameter int        MODULUS = 25,
    parameter int        ROOT    = 2,
    parameter int        BASE    = 5,
    parameter int        AW      = 5,
    parameter int        BW      = 1,
    localparam int       VW      = $clog2(MODULUS),
    localparam int       CW      = AW + BW + 1
) (
    input  logic [CW-1:0] code_i,
    input  logic          zero_i,
    output logic [VW-1:0] val_o
);

    localparam int DEPTH = 1 << CW;

    logic [VW-1:0] inv_rom [DEPTH];

    // One constant residue per code, computed at elaboration
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int F_ALPHA = k & ((1 << AW) - 1);
        localparam int F_BETA  = (k >> AW) & ((1 << BW) - 1);
        localparam int F_GAMMA = k >> (AW + BW);
        localparam int R_VAL   = code_value(KIND, MODULUS, ROOT, BASE,
                                            F_ALPHA, F_BETA, F_GAMMA);
        assign inv_rom[k] = VW'(R_VAL);
    end

    // Table read with zero override
    always_comb begin
        val_o = zero_i ? '0 : inv_rom[code_i];
    end

endmodule

// File: rtl/modmul_index.sv
// Index-calculus modular multiplier, top level.
// Stage 1 registers the forward codes of both operands; stage 2 registers
// the product after index addition and inverse lookup. Latency two cycles.
// Assumes operands below MODULUS, and MODULUS = BASE**EXPONENT
// (BASE = 2 and EXPONENT >= 3 for MOD_POW2, EXPONENT = 1 for MOD_PRIME).
module modmul_index
    import modmul_pkg::*;
#(
    parameter mod_kind_e KIND     = MOD_ODD_POW,
    parameter int        MODULUS  = 25,
    parameter int        ROOT     = 2,
    parameter int        BASE     = 5,
    parameter int        EXPONENT = 2,
    localparam int       VW       = $clog2(MODULUS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld_i,
    input  logic [VW-1:0] opa_i,
    input  logic [VW-1:0] opb_i,
    output logic          out_vld_o,
    output logic [VW-1:0] prod_o
);

    localparam int PHI = (KIND == MOD_PRIME)   ? MODULUS - 1 :
                         (KIND == MOD_ODD_POW) ? (MODULUS / BASE) * (BASE - 1) :
                                                 (1 << (EXPONENT - 2));
    localparam int ALPHA_LIM = (KIND == MOD_POW2) ? EXPONENT : PHI;
    localparam int BETA_LIM  = (KIND == MOD_PRIME)   ? 1 :
                               (KIND == MOD_ODD_POW) ? EXPONENT : PHI;
    localparam int GAMMA_LIM = (KIND == MOD_POW2) ? 2 : 1;
    localparam int AW = (ALPHA_LIM > 1) ? $clog2(ALPHA_LIM) : 1;
    localparam int BW = (BETA_LIM > 1)  ? $clog2(BETA_LIM)  : 1;
    localparam int CW = AW + BW + 1;

    logic [CW-1:0] code_a, code_b, code_a_q, code_b_q, code_sum;
    logic          zero_a, zero_b, zero_a_q, zero_b_q, zero_sum;
    logic          vld_q;
    logic [VW-1:0] prod_d;

    modmul_fwd_rom #(
        .KIND(KIND), .MODULUS(MODULUS), .ROOT(ROOT), .BASE(BASE),
        .AW(AW), .BW(BW), .ALPHA_LIM(ALPHA_LIM), .BETA_LIM(BETA_LIM),
        .GAMMA_LIM(GAMMA_LIM)
    ) u_fwd_a (.val_i(opa_i), .code_o(code_a), .zero_o(zero_a));

    modmul_fwd_rom #(
        .KIND(KIND), .MODULUS(MODULUS), .ROOT(ROOT), .BASE(BASE),
        .AW(AW), .BW(BW), .ALPHA_LIM(ALPHA_LIM), .BETA_LIM(BETA_LIM),
        .GAMMA_LIM(GAMMA_LIM)
    ) u_fwd_b (.val_i(opb_i), .code_o(code_b), .zero_o(zero_b));

    // Stage 1: capture operand codes and zero flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= 1'b0;
            code_a_q <= '0;
            code_b_q <= '0;
            zero_a_q <= 1'b1;
            zero_b_q <= 1'b1;
        end else begin
            vld_q <= in_vld_i;
            if (in_vld_i) begin
                code_a_q <= code_a;
                code_b_q <= code_b;
                zero_a_q <= zero_a;
                zero_b_q <= zero_b;
            end
        end
    end

    modmul_idx_add #(
        .KIND(KIND), .EXPONENT(EXPONENT), .AW(AW), .BW(BW),
        .ALPHA_LIM(ALPHA_LIM)
    ) u_add (
        .code_a_i(code_a_q), .code_b_i(code_b_q),
        .zero_a_i(zero_a_q), .zero_b_i(zero_b_q),
        .code_o(code_sum), .zero_o(zero_sum)
    );

    modmul_inv_rom #(
        .KIND(KIND), .MODULUS(MODULUS), .ROOT(ROOT), .BASE(BASE),
        .AW(AW), .BW(BW)
    ) u_inv (.code_i(code_sum), .zero_i(zero_sum), .val_o(prod_d));

    // Stage 2: register the rebuilt product and its valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            prod_o    <= '0;
        end else begin
            out_vld_o <= vld_q;
            if (vld_q) begin
                prod_o <= prod_d;
            end
        end
    end

    // R1
    lat_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> ##1 out_vld_o);

    // R1
    lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> ##1 !out_vld_o);

    // R3
    zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld_i && (opa_i == '0 || opb_i == '0)) |=> ##1 (prod_o == '0));

    // R10
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |-> (int'(opa_i) < MODULUS && int'(opb_i) < MODULUS));

    // R10
    out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> (int'(prod_o) < MODULUS));

    if (KIND == MOD_PRIME) begin : g_chk_prime
        // R2
        no_zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld_i && opa_i != '0 && opb_i != '0) |=> ##1 (prod_o != '0));
    end else if (KIND == MOD_ODD_POW) begin : g_chk_odd
        // R4
        unit_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld_i && (int'(opa_i) % BASE != 0) && (int'(opb_i) % BASE != 0))
            |=> ##1 (int'(prod_o) % BASE != 0));
    end else begin : g_chk_pow2
        // R6
        parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld_i |=> ##1 (prod_o[0] == ($past(opa_i[0], 2) & $past(opb_i[0], 2))));
    end

endmodule

// File: tb/modmul_index_tb.sv
// Scoreboard bench: one instance per modulus, each swept over all pairs.
module modmul_index_tb;
    import modmul_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CFG    = 8;
    localparam int WATCHDOG   = 20000;

    function automatic mod_kind_e cfg_kind(input int k);
        return (k < 6) ? MOD_PRIME : (k == 6) ? MOD_ODD_POW : MOD_POW2;
    endfunction

    function automatic int cfg_mod(input int k);
        case (k)
            0: return 29;  1: return 31;  2: return 37;  3: return 43;
            4: return 47;  5: return 59;  6: return 25;  default: return 64;
        endcase
    endfunction

    function automatic int cfg_root(input int k);
        case (k)
            0: return 2;  1: return 3;  2: return 2;  3: return 3;
            4: return 5;  5: return 2;  6: return 2;  default: return 5;
        endcase
    endfunction

    function automatic int cfg_base(input int k);
        return (k < 6) ? cfg_mod(k) : (k == 6) ? 5 : 2;
    endfunction

    function automatic int cfg_exp(input int k);
        return (k < 6) ? 1 : (k == 6) ? 2 : 6;
    endfunction

    function automatic int tz(input int v, input int lim);
        int n = 0;
        int x = v;
        while (x % 2 == 0 && n < lim) begin
            x = x / 2;
            n++;
        end
        return n;
    endfunction

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   cycle_cnt = 0;
    wire  [NUM_CFG-1:0] done;
    wire  [31:0] chk_w [NUM_CFG];
    wire  [31:0] err_w [NUM_CFG];

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cycle_cnt <= cycle_cnt + 1;

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        localparam mod_kind_e K = cfg_kind(k);
        localparam int M  = cfg_mod(k);
        localparam int B  = cfg_base(k);
        localparam int E  = cfg_exp(k);
        localparam int VW = $clog2(M);

        typedef struct {
            int a;
            int b;
            int expv;
            int due;
        } item_t;

        item_t sb_q[$];
        logic  vld_in = 1'b0;
        logic  [VW-1:0] opa = '0;
        logic  [VW-1:0] opb = '0;
        logic  vld_out;
        logic  [VW-1:0] prod;
        bit    blk_done = 1'b0;
        int    n_checks = 0;
        int    n_errors = 0;

        assign done[k]  = blk_done;
        assign chk_w[k] = n_checks;
        assign err_w[k] = n_errors;

        modmul_index #(
            .KIND(K), .MODULUS(M), .ROOT(cfg_root(k)), .BASE(B), .EXPONENT(E)
        ) u_dut (
            .clk(clk), .rst_n(rst_n), .in_vld_i(vld_in),
            .opa_i(opa), .opb_i(opb), .out_vld_o(vld_out), .prod_o(prod)
        );

        // Requirement that governs a given pair
        function automatic string req_tag(input int a, input int b);
            if (a == 0 || b == 0) return "R3";
            if (K == MOD_PRIME) return "R2";
            if (K == MOD_ODD_POW) return (a % B == 0 && b % B == 0) ? "R5" : "R4";
            if (tz(a, E) + tz(b, E) == E - 1) return "R7";
            if (tz(a, E) + tz(b, E) > E - 1) return "R8";
            return "R6";
        endfunction

        task automatic drive(input int a, input int b);
            item_t it;
            @(negedge clk);
            vld_in = 1'b1;
            opa    = VW'(a);
            opb    = VW'(b);
            it.a = a; it.b = b; it.expv = (a * b) % M; it.due = cycle_cnt + 2;
            sb_q.push_back(it);
        endtask

        task automatic idle();
            @(negedge clk);
            vld_in = 1'b0;
        endtask

        // Driver: every pair, with idle gaps at irregular points
        initial begin
            wait (rst_n === 1'b1);
            for (int a = 0; a < M; a++) begin
                for (int b = 0; b < M; b++) begin
                    if ((a * 7 + b) % 11 == 0) idle();
                    drive(a, b);
                end
            end
            idle();
            while (sb_q.size() != 0) @(negedge clk);
            repeat (3) @(negedge clk);
            blk_done = 1'b1;
        end

        // Monitor: reset state, timing, value and range per output
        always @(negedge clk) begin
            item_t it;
            if (!rst_n) begin
                if (cycle_cnt > 0) begin
                    n_checks++;
                    if (vld_out !== 1'b0 || prod !== '0) begin
                        n_errors++;
                        $display("FAIL R9 m=%0d reset: got vld=%0b prod=%0d expected vld=0 prod=0",
                                 M, vld_out, prod);
                    end
                end
            end else if (vld_out === 1'b1) begin
                if (sb_q.size() == 0) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL R1 m=%0d unexpected valid: got 1 expected 0", M);
                end else begin
                    it = sb_q.pop_front();
                    n_checks++;
                    if (cycle_cnt != it.due) begin
                        n_errors++;
                        $display("FAIL R1 m=%0d a=%0d b=%0d: got cycle %0d expected cycle %0d",
                                 M, it.a, it.b, cycle_cnt, it.due);
                    end
                    n_checks++;
                    if (int'(prod) != it.expv) begin
                        n_errors++;
                        $display("FAIL %s m=%0d a=%0d b=%0d: got %0d expected %0d",
                                 req_tag(it.a, it.b), M, it.a, it.b, prod, it.expv);
                    end
                    n_checks++;
                    if (int'(prod) >= M) begin
                        n_errors++;
                        $display("FAIL R10 m=%0d a=%0d b=%0d: got %0d expected below %0d",
                                 M, it.a, it.b, prod, M);
                    end
                end
            end
        end
    end

    // Reset, completion wait with watchdog, summary
    initial begin
        int total_checks;
        int total_errors;
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        while (done != {NUM_CFG{1'b1}} && cycle_cnt < WATCHDOG) @(posedge clk);
        @(negedge clk);
        total_checks = 0;
        total_errors = 0;
        for (int k = 0; k < NUM_CFG; k++) begin
            total_checks += int'(chk_w[k]);
            total_errors += int'(err_w[k]);
        end
        if (done != {NUM_CFG{1'b1}}) begin
            total_checks++;
            total_errors++;
            $display("FAIL R1 watchdog expired: got done=%b expected all ones", done);
        end
        $display("Simulation finished: %0d checks, %0d errors", total_checks, total_errors);
        $finish;
    end

endmodule